// File: doc/BRIEF.md
# MMC command path controller

This block sends one command frame on the serial command line of an MMC/SD card and, when asked to, collects the card's reply. Software-facing logic loads a 32-bit argument first, then writes the command index together with two response flags (wait for a response, long response) and a go bit. The block serialises a 48-bit frame with its CRC7, releases the line, and then either finishes at once or looks for the card's start bit within a bounded window and shifts in a 48-bit or 136-bit reply.

The block keeps sticky status bits that software clears by writing ones to a separate clear input: frame sent, reply received, no reply (timeout) and reply check failed. A live "in progress" bit shows that a command is running. Reply payloads land in four 32-bit words. Each clock cycle of `clk` is one card-clock bit period: the line is driven and sampled once per cycle.

Top module: `mmc_cmd_engine`

## Requirements
- R1: After a synchronous reset, `status` reads 0, `cmd_out` is 1, `cmd_oe` is 0 and all four response words read 0.
- R2: A command starts only on a cycle with `cmd_we` and `cmd_enable` both high while no command is running; a write with `cmd_enable` low, or any command write while a command runs, changes nothing on the line or in the status.
- R3: On the cycle after the starting write, `cmd_oe` goes high for exactly 48 cycles and `cmd_out` carries, MSB first, a 0, a 1, the 6-bit index, the 32-bit argument taken from the last `arg_we`, the CRC7 (x^7+x^3+1, initial value 0) of those 40 bits, and a closing 1; the line idles at 1 otherwise.
- R4: With the wait-for-response flag clear, status bit 7 (sent) is set in the cycle after the closing bit is driven, and `cmd_in` is not looked at.
- R5: With the wait flag set and the long flag clear, the block looks for a 0 on `cmd_in` from the first cycle after the closing bit, captures 48 bits, and one cycle after the last bit sets status bit 6 (reply received) when the CRC7 over the first 40 received bits matches bits 7..1; word 0 then holds reply bits 39..8 and words 1..3 hold 0.
- R6: With both flags set, 136 bits are captured; the CRC7 covers reply bits 127..8 only; words 0..3 hold reply bits 127..96, 95..64, 63..32 and 31..1 followed by a 0.
- R7: A CRC mismatch or a low closing bit in the reply sets status bit 0 (check failed) instead of bit 6; the response words are loaded anyway.
- R8: If `cmd_in` stays 1 for 64 sampled cycles after the closing bit, status bit 2 (timeout) is set at the 64th; a start bit found at the 64th sample is taken as a reply.
- R9: Writing `clr_we` with ones in `clr_wdata` clears the matching sticky bits (0, 2, 6, 7); zero bits leave them alone; a set in the same cycle wins over a clear.
- R10: Status bit 11 (in progress) is 1 from the cycle the start bit is driven until the cycle the finishing status bit appears, and cannot be cleared by `clr_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card-rate clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| arg_we | input | 1 | Load strobe for the argument |
| arg_wdata | input | 32 | Command argument |
| cmd_we | input | 1 | Command write strobe |
| cmd_index | input | 6 | Command index |
| cmd_wait_resp | input | 1 | Expect a reply |
| cmd_long_resp | input | 1 | Reply is 136 bits (with cmd_wait_resp) |
| cmd_enable | input | 1 | Go bit, must accompany cmd_we |
| clr_we | input | 1 | Status clear strobe |
| clr_wdata | input | 12 | Ones clear matching status bits |
| cmd_in | input | 1 | Serial command line from the card |
| cmd_out | output | 1 | Serial command line to the card |
| cmd_oe | output | 1 | Drive enable for cmd_out |
| resp_words | output | 128 | Word k at bits 32k+31..32k |
| status | output | 12 | Bit 0 check fail, 2 timeout, 6 reply, 7 sent, 11 in progress |

## Verification
The bench goes after the edges of the reply window: a start bit on the very last permitted sample must still be accepted, while a silent line must raise the timeout on exactly the 64th sample; a design off by one would either lose a valid reply or report the timeout a cycle early or late. Corrupted CRC fields in both reply lengths check that the long reply's CRC span skips the start, transmission and reserved bits, since a design hashing the wrong span would fail good replies. Command writes and an all-ones clear are injected mid-frame to catch a design that restarts on a busy write or lets software drop the in-progress bit, and a no-reply command runs with the line pulled low to catch one that listens when it should not.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;

  localparam int STAT_W       = 12;
  localparam int ST_CRC_FAIL  = 0;
  localparam int ST_TIMEOUT   = 2;
  localparam int ST_RESP_DONE = 6;
  localparam int ST_SENT      = 7;
  localparam int ST_ACTIVE    = 11;

  localparam logic [STAT_W-1:0] STICKY_BITS =
    STAT_W'((1 << ST_CRC_FAIL) | (1 << ST_TIMEOUT) | (1 << ST_RESP_DONE) | (1 << ST_SENT));

  localparam int CRC_IN_W = 120;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TX,
    S_WAIT,
    S_RX,
    S_CHK
  } cmd_state_e;

  // CRC7 with generator x^7+x^3+1 over the top nbits of bits, MSB first.
  function automatic logic [6:0] crc7_msb(input logic [CRC_IN_W-1:0] bits, input int nbits);
    logic [6:0] r;
    logic       fb;
    r = '0;
    for (int i = 0; i < CRC_IN_W; i++) begin
      if (i < nbits) begin
        fb = bits[CRC_IN_W-1-i] ^ r[6];
        r  = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mmc_cmd_status.sv
module mmc_cmd_status
  import mmc_cmd_pkg::*;
#(
  parameter int              W       = STAT_W,
  parameter logic [W-1:0]    STICKY  = STICKY_BITS,
  parameter int              ACT_BIT = ST_ACTIVE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_pulse,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic         active,
  output logic [W-1:0] status
);

  logic unused_bits;
  assign unused_bits = ^{set_pulse & ~STICKY, clr_mask & ~STICKY};

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (STICKY[b]) begin : g_sticky
      logic flag_q;
      always_ff @(posedge clk) begin
        if (rst)                       flag_q <= 1'b0;
        else if (set_pulse[b])         flag_q <= 1'b1;
        else if (clr_we && clr_mask[b]) flag_q <= 1'b0;
      end
      assign status[b] = flag_q;

      // R9
      w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_mask[b] && !set_pulse[b]) |=> !status[b]);
      // R9
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_pulse[b] |=> status[b]);
    end else if (b == ACT_BIT) begin : g_active
      assign status[b] = active;
    end else begin : g_zero
      assign status[b] = 1'b0;
    end
  end

endmodule

// File: rtl/mmc_cmd_resp_cap.sv
module mmc_cmd_resp_cap #(
  parameter int WORD_W    = 32,
  parameter int WORDS     = 4,
  parameter int SHORT_LSB = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      long_sel,
  input  logic [WORDS*WORD_W-1:1]   frame,
  output logic [WORDS*WORD_W-1:0]   words
);

  localparam int TOP = WORDS * WORD_W;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [WORD_W-1:0] long_val;
    logic [WORD_W-1:0] short_val;
    logic [WORD_W-1:0] word_q;

    if (k == WORDS - 1) begin : g_last
      assign long_val = {frame[WORD_W-1:1], 1'b0};
    end else begin : g_mid
      assign long_val = frame[TOP-1-k*WORD_W -: WORD_W];
    end

    if (k == 0) begin : g_first
      assign short_val = frame[SHORT_LSB+WORD_W-1:SHORT_LSB];
    end else begin : g_blank
      assign short_val = '0;
    end

    always_ff @(posedge clk) begin
      if (rst)       word_q <= '0;
      else if (load) word_q <= long_sel ? long_val : short_val;
    end

    assign words[k*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine
  import mmc_cmd_pkg::*;
#(
  parameter int ARG_W          = 32,
  parameter int IDX_W          = 6,
  parameter int TIMEOUT_CYCLES = 64,
  parameter int RESP_WORDS     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        arg_we,
  input  logic [ARG_W-1:0]            arg_wdata,
  input  logic                        cmd_we,
  input  logic [IDX_W-1:0]            cmd_index,
  input  logic                        cmd_wait_resp,
  input  logic                        cmd_long_resp,
  input  logic                        cmd_enable,
  input  logic                        clr_we,
  input  logic [STAT_W-1:0]           clr_wdata,
  input  logic                        cmd_in,
  output logic                        cmd_out,
  output logic                        cmd_oe,
  output logic [RESP_WORDS*32-1:0]    resp_words,
  output logic [STAT_W-1:0]           status
);

  localparam int HDR_W     = 2 + IDX_W + ARG_W;
  localparam int TX_BITS   = HDR_W + 8;
  localparam int LONG_BITS = 136;
  localparam int KEEP_BITS = RESP_WORDS * 32;
  localparam int TX_CNT_W  = $clog2(TX_BITS + 1);
  localparam int RX_CNT_W  = $clog2(LONG_BITS + 1);
  localparam int TMR_W     = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [STAT_W-1:0] DONE_MASK = STICKY_BITS;

  cmd_state_e            state;
  logic [TX_BITS-1:0]    tx_sh;
  logic [TX_CNT_W-1:0]   tx_cnt;
  logic                  oe_q;
  logic                  wait_q;
  logic                  long_q;
  logic                  active_q;
  logic [ARG_W-1:0]      arg_q;
  logic [TMR_W-1:0]      tmr;
  logic [RX_CNT_W-1:0]   rx_cnt;
  logic [KEEP_BITS-1:0]  rx_sh;

  // Outgoing frame built from the index on the bus and the stored argument
  logic [HDR_W-1:0]   tx_hdr;
  logic [6:0]         tx_crc;
  logic [TX_BITS-1:0] tx_frame;
  assign tx_hdr   = {2'b01, cmd_index, arg_q};
  assign tx_crc   = crc7_msb({tx_hdr, {(CRC_IN_W-HDR_W){1'b0}}}, HDR_W);
  assign tx_frame = {tx_hdr, tx_crc, 1'b1};

  logic tx_last;
  logic wait_expire;
  logic rx_last;
  assign tx_last     = (state == S_TX) && (tx_cnt == TX_CNT_W'(TX_BITS - 1));
  assign wait_expire = (state == S_WAIT) && cmd_in && (tmr == TMR_W'(TIMEOUT_CYCLES - 1));
  assign rx_last     = rx_cnt == (long_q ? RX_CNT_W'(LONG_BITS - 1) : RX_CNT_W'(TX_BITS - 1));

  // Reply check, evaluated in the cycle after the last bit arrives
  logic [6:0] rx_crc_calc;
  logic       rx_good;
  always_comb begin
    if (long_q) rx_crc_calc = crc7_msb(rx_sh[KEEP_BITS-1:8], CRC_IN_W);
    else        rx_crc_calc = crc7_msb({rx_sh[TX_BITS-1:8], {(CRC_IN_W-HDR_W){1'b0}}}, HDR_W);
    rx_good = (rx_crc_calc == rx_sh[7:1]) && rx_sh[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      tx_sh    <= '1;
      tx_cnt   <= '0;
      oe_q     <= 1'b0;
      wait_q   <= 1'b0;
      long_q   <= 1'b0;
      active_q <= 1'b0;
      arg_q    <= '0;
      tmr      <= '0;
      rx_cnt   <= '0;
      rx_sh    <= '0;
    end else begin
      if (arg_we) arg_q <= arg_wdata;
      case (state)
        S_IDLE: begin
          if (cmd_we && cmd_enable) begin
            wait_q   <= cmd_wait_resp;
            long_q   <= cmd_wait_resp && cmd_long_resp;
            tx_sh    <= tx_frame;
            tx_cnt   <= '0;
            oe_q     <= 1'b1;
            active_q <= 1'b1;
            state    <= S_TX;
          end
        end
        S_TX: begin
          tx_sh <= {tx_sh[TX_BITS-2:0], 1'b1};
          if (tx_last) begin
            oe_q <= 1'b0;
            if (wait_q) begin
              tmr   <= '0;
              state <= S_WAIT;
            end else begin
              active_q <= 1'b0;
              state    <= S_IDLE;
            end
          end else begin
            tx_cnt <= tx_cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (!cmd_in) begin
            rx_sh  <= {rx_sh[KEEP_BITS-2:0], cmd_in};
            rx_cnt <= RX_CNT_W'(1);
            state  <= S_RX;
          end else if (wait_expire) begin
            active_q <= 1'b0;
            state    <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_RX: begin
          rx_sh <= {rx_sh[KEEP_BITS-2:0], cmd_in};
          if (rx_last) state <= S_CHK;
          else         rx_cnt <= rx_cnt + 1'b1;
        end
        S_CHK: begin
          active_q <= 1'b0;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [STAT_W-1:0] set_v;
  always_comb begin
    set_v               = '0;
    set_v[ST_SENT]      = tx_last && !wait_q;
    set_v[ST_TIMEOUT]   = wait_expire;
    set_v[ST_RESP_DONE] = (state == S_CHK) && rx_good;
    set_v[ST_CRC_FAIL]  = (state == S_CHK) && !rx_good;
  end

  mmc_cmd_status #(
    .W       (STAT_W),
    .STICKY  (STICKY_BITS),
    .ACT_BIT (ST_ACTIVE)
  ) u_status (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (set_v),
    .clr_we    (clr_we),
    .clr_mask  (clr_wdata),
    .active    (active_q),
    .status    (status)
  );

  mmc_cmd_resp_cap #(
    .WORD_W    (32),
    .WORDS     (RESP_WORDS),
    .SHORT_LSB (8)
  ) u_resp (
    .clk      (clk),
    .rst      (rst),
    .load     (state == S_CHK),
    .long_sel (long_q),
    .frame    (rx_sh[KEEP_BITS-1:1]),
    .words    (resp_words)
  );

  assign cmd_out = tx_sh[TX_BITS-1];
  assign cmd_oe  = oe_q;

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_oe |-> cmd_out);
  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ((state != S_IDLE) && cmd_we && cmd_enable) |=> !((state == S_TX) && (tx_cnt == '0)));
  // R4
  sent_path_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_SENT]) |-> !wait_q);
  // R5
  resp_path_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_RESP_DONE]) |-> wait_q);
  // R8
  timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> (tmr < TMR_W'(TIMEOUT_CYCLES)));
  // R10
  active_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status[ST_ACTIVE]) |-> ((status & DONE_MASK) != '0));

endmodule

// File: tb/mmc_cmd_engine_tb_top.sv
module mmc_cmd_engine_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic        wresp;
    logic        lresp;
    logic        bad;
    logic [6:0]  dly;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b0, 7'd0},
    '{6'd17, 32'h1234_5678, 1'b1, 1'b0, 1'b0, 7'd3},
    '{6'd2,  32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 7'd0},
    '{6'd13, 32'hA5A5_0F0F, 1'b1, 1'b0, 1'b1, 7'd63},
    '{6'd63, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 7'd10},
    '{6'd55, 32'h8000_0001, 1'b0, 1'b0, 1'b0, 7'd0}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         arg_we;
  logic [31:0]  arg_wdata;
  logic         cmd_we;
  logic [5:0]   cmd_index;
  logic         cmd_wait_resp;
  logic         cmd_long_resp;
  logic         cmd_enable;
  logic         clr_we;
  logic [11:0]  clr_wdata;
  logic         cmd_in;
  logic         cmd_out;
  logic         cmd_oe;
  logic [127:0] resp_words;
  logic [11:0]  status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmc_cmd_engine dut_i (
    .clk           (clk),
    .rst           (rst),
    .arg_we        (arg_we),
    .arg_wdata     (arg_wdata),
    .cmd_we        (cmd_we),
    .cmd_index     (cmd_index),
    .cmd_wait_resp (cmd_wait_resp),
    .cmd_long_resp (cmd_long_resp),
    .cmd_enable    (cmd_enable),
    .clr_we        (clr_we),
    .clr_wdata     (clr_wdata),
    .cmd_in        (cmd_in),
    .cmd_out       (cmd_out),
    .cmd_oe        (cmd_oe),
    .resp_words    (resp_words),
    .status        (status)
  );

  function automatic logic [6:0] tb_crc(input logic [119:0] d, input int n);
    logic [6:0] g;
    logic       m;
    g = 7'd0;
    for (int i = 0; i < n; i++) begin
      m    = g[6] ^ d[119-i];
      g    = g << 1;
      g[0] = m;
      g[3] = g[3] ^ m;
    end
    return g;
  endfunction

  task automatic chkw(input string req, input string what, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk1(input string req, input string what, input logic act, input logic exp);
    chkw(req, what, 136'(act), 136'(exp));
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_we    = 1'b1;
    clr_wdata = 12'hFFF;
    @(negedge clk);
    clr_we    = 1'b0;
    clr_wdata = 12'h000;
  endtask

  // Issue one command, capture the frame, play the card, check the outcome.
  task automatic run_cmd(input vec_t v, input bit disturb, input bit no_card);
    logic [47:0]  got;
    logic [47:0]  exp_frame;
    logic [39:0]  hdr;
    logic         oe_ok;
    logic [119:0] pay;
    logic [6:0]   c;
    logic [135:0] rf;
    int           rlen;
    logic [127:0] exp_w;

    clear_all();
    arg_we    = 1'b1;
    arg_wdata = v.arg;
    cmd_in    = v.wresp;
    @(negedge clk);
    arg_we        = 1'b0;
    arg_wdata     = 32'h0BAD_0BAD;
    cmd_we        = 1'b1;
    cmd_index     = v.idx;
    cmd_wait_resp = v.wresp;
    cmd_long_resp = v.lresp;
    cmd_enable    = 1'b1;

    hdr       = {2'b01, v.idx, v.arg};
    exp_frame = {hdr, tb_crc({hdr, 80'd0}, 40), 1'b1};
    oe_ok     = 1'b1;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (i == 0) cmd_we = 1'b0;
      got[47-i] = cmd_out;
      oe_ok     = oe_ok & cmd_oe;
      if (disturb && i == 10) begin
        cmd_we    = 1'b1;
        cmd_index = ~v.idx;
        clr_we    = 1'b1;
        clr_wdata = 12'hFFF;
      end
      if (disturb && i == 11) begin
        cmd_we    = 1'b0;
        clr_we    = 1'b0;
        clr_wdata = 12'h000;
        chk1("R10", "in-progress bit after clear write", status[11], 1'b1);
      end
    end
    chkw("R3", "frame bits", 136'(got), 136'(exp_frame));
    chk1("R3", "drive enable over frame", oe_ok, 1'b1);

    if (!v.wresp) begin
      @(negedge clk);
      cmd_in = 1'b1;
      chk1("R4", "sent bit", status[7], 1'b1);
      chk1("R4", "no reply bit", status[6], 1'b0);
      chk1("R10", "in progress dropped", status[11], 1'b0);
      chk1("R3", "line released", cmd_oe, 1'b0);
    end else if (no_card) begin
      repeat (64) @(negedge clk);
      chk1("R8", "timeout early", status[2], 1'b0);
      chk1("R10", "in progress while waiting", status[11], 1'b1);
      @(negedge clk);
      chk1("R8", "timeout bit", status[2], 1'b1);
      chk1("R8", "no reply on timeout", status[6], 1'b0);
      chk1("R10", "in progress after timeout", status[11], 1'b0);
    end else begin
      rf = '1;
      if (v.lresp) begin
        pay  = {v.arg, ~v.arg, v.arg ^ 32'hA5A5_A5A5, v.arg[23:0]};
        c    = tb_crc(pay, 120) ^ {6'd0, v.bad};
        rf   = {2'b00, 6'b111111, pay, c, 1'b1};
        rlen = 136;
        exp_w = {{pay[23:0], c, 1'b0}, v.arg ^ 32'hA5A5_A5A5, ~v.arg, v.arg};
      end else begin
        c    = tb_crc({2'b00, v.idx, ~v.arg, 80'd0}, 40) ^ {6'd0, v.bad};
        rf[47:0] = {2'b00, v.idx, ~v.arg, c, 1'b1};
        rlen = 48;
        exp_w = {96'd0, ~v.arg};
      end
      for (int j = 0; j < int'(v.dly); j++) begin
        @(negedge clk);
        cmd_in = 1'b1;
      end
      for (int j = rlen - 1; j >= 0; j--) begin
        @(negedge clk);
        cmd_in = rf[j];
      end
      @(negedge clk);
      cmd_in = 1'b1;
      chk1(v.lresp ? "R6" : "R5", "in progress during check", status[11], 1'b1);
      chk1("R8", "no timeout with late start", status[2], 1'b0);
      @(negedge clk);
      if (v.bad) begin
        chk1("R7", "check-fail bit", status[0], 1'b1);
        chk1("R7", "reply bit held off", status[6], 1'b0);
        chkw("R7", "words loaded anyway", 136'(resp_words), 136'(exp_w));
      end else begin
        chk1(v.lresp ? "R6" : "R5", "reply bit", status[6], 1'b1);
        chk1(v.lresp ? "R6" : "R5", "no check fail", status[0], 1'b0);
        chkw(v.lresp ? "R6" : "R5", "reply words", 136'(resp_words), 136'(exp_w));
      end
      chk1("R10", "in progress after reply", status[11], 1'b0);
    end
  endtask

  initial begin
    rst = 1'b1; arg_we = 1'b0; arg_wdata = '0; cmd_we = 1'b0; cmd_index = '0;
    cmd_wait_resp = 1'b0; cmd_long_resp = 1'b0; cmd_enable = 1'b0;
    clr_we = 1'b0; clr_wdata = '0; cmd_in = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chkw("R1", "status after reset", 136'(status), 136'(12'h000));
    chk1("R1", "line after reset", cmd_out, 1'b1);
    chk1("R1", "drive enable after reset", cmd_oe, 1'b0);
    chkw("R1", "words after reset", 136'(resp_words), 136'd0);

    // Command write without the go bit
    cmd_we = 1'b1; cmd_index = 6'd5; cmd_enable = 1'b0;
    @(negedge clk);
    cmd_we = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk1("R2", "no drive without go bit", cmd_oe, 1'b0);
      chk1("R2", "not in progress without go bit", status[11], 1'b0);
      @(negedge clk);
    end

    for (int n = 0; n < NV; n++) run_cmd(VECS[n], 1'b0, 1'b0);

    // Busy writes and a full clear during a frame
    run_cmd(VECS[1], 1'b1, 1'b0);

    // Silent card
    run_cmd('{6'd9, 32'h0F0F_F0F0, 1'b1, 1'b0, 1'b0, 7'd0}, 1'b0, 1'b1);

    // Clear semantics on the sent bit
    run_cmd(VECS[0], 1'b0, 1'b0);
    @(negedge clk);
    clr_we = 1'b1; clr_wdata = 12'hF7F;
    @(negedge clk);
    clr_we = 1'b0; clr_wdata = 12'h000;
    chk1("R9", "zero bit keeps sent", status[7], 1'b1);
    clr_we = 1'b1; clr_wdata = 12'h080;
    @(negedge clk);
    clr_we = 1'b0; clr_wdata = 12'h000;
    chkw("R9", "one bit clears sent", 136'(status), 136'(12'h000));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule